// File: doc/BRIEF.md
# Descriptor-Chained Receive DMA Engine

This block takes the bytes of received frames, as a byte stream with an end-of-frame flag, and stores them in system memory. Where each frame goes is set by a chain of three-word descriptors in memory. The engine reads a descriptor and checks that it owns it. It then packs the frame bytes into 32-bit words and writes them in bursts to the buffer that the descriptor names. After the frame it writes the byte count and an error flag back over the owner word, which also returns the descriptor to software, and moves on to the next link.

Software sets up the engine through a small register port. The control word holds the burst size, the byte order, the address direction, the number of leading pad bytes, the action taken on a descriptor the engine does not own, the enable bit and a soft reset bit. There is also a 26-bit descriptor pointer and a 16-bit storage limit. The engine turns its own enable off when the chain ends in a zero pointer, and also when it meets a descriptor it does not own while the stop option is set. It latches the 16-bit length/type field of the frame in flight and pulses an early notification when that field is complete.

Top module: `rx_desc_dma`

## Requirements
- R1: After the synchronous reset, `rx_en` is 0, `desc_ptr` is all ones, `in_ready` is 0 and `mem_req` is 0.
- R2: Register writes go to `reg_addr` 0 for control, 1 for the descriptor pointer (bits 25:0) and 2 for the storage limit (bits 15:0). A descriptor is three words at word addresses p, p+1 and p+2. Word p holds the owner flag in bit 31, word p+1 holds the buffer address in bits 25:0 and word p+2 holds the next pointer in bits 25:0. After an owned descriptor's frame has been stored, `desc_ptr` equals that descriptor's next pointer.
- R3: If `rx_en` (set by control bit 10) is 1 while `desc_ptr` is zero, the engine clears `rx_en`, pulses `evt_null` and makes no memory access.
- R4: For a descriptor whose owner bit is 0, the engine pulses `evt_not_owner` and stores no data. With control bit 5 set it clears `rx_en` and keeps `desc_ptr`. With control bit 5 clear it loads the next pointer and goes on along the chain.
- R5: At end of frame the engine writes word p of the descriptor with bit 31 = 0, bit 16 = over-limit flag and bits 15:0 = number of bytes received. It then pulses `evt_done`.
- R6: Data words are written in back-to-back runs of (control[4:0] + 1) words. Only the last run of a frame may be shorter. `in_ready` is 0 in every cycle in which `mem_req` is 1.
- R7: Control bits 9:8 give a pad count of 0 to 3. The first data word of a frame holds that many zero bytes ahead of the first frame byte.
- R8: With control bit 7 at 0, byte slot k of a word (k = 0..3 in stream order) sits at bits 31-8k down to 24-8k. With bit 7 at 1 it sits at bits 8k+7 down to 8k.
- R9: With control bit 6 at 0, successive data words go to the buffer address plus 0, 1, 2 and so on. With bit 6 at 1 they go to the buffer address minus 0, 1, 2 and so on.
- R10: Only the first `limit` bytes of a frame are stored. A frame longer than `limit` sets the over-limit flag in the status word and pulses `evt_max_over` together with `evt_done`. A frame of exactly `limit` bytes does neither.
- R11: Frame bytes 12 and 13 (counting from 0) are latched into `len_type`, byte 12 as the high byte, whether or not they are stored. `evt_early` pulses once this field is complete.
- R12: Writing control with bit 11 set returns the engine to idle with `rx_en` = 0. A partly received frame is dropped, and neither its data nor its status is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 pointer, 2 limit |
| reg_wdata | input | 32 | Register write data |
| rx_en | output | 1 | Current enable state |
| desc_ptr | output | 26 | Current descriptor pointer |
| len_type | output | 16 | Latched length/type field |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| in_ready | output | 1 | Engine takes the input byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 26 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with ack |
| evt_done | output | 1 | Pulse: frame stored and descriptor returned |
| evt_null | output | 1 | Pulse: stopped on zero pointer |
| evt_not_owner | output | 1 | Pulse: descriptor not owned |
| evt_max_over | output | 1 | Pulse: frame exceeded limit |
| evt_early | output | 1 | Pulse: length/type field latched |

## Verification
The bench builds the engine with its defaults, a 26-bit address and a 32-word burst store. This lets the control field select bursts of 1, 2 and 4 words within a single build, so full runs, short final runs and single-word runs all appear. The scenarios combine the two byte orders with both address directions and pad counts 0, 1 and 3. They include a frame cut by the storage limit and a frame that fills the limit exactly. The two chains end in the two ways the engine stops itself: a zero pointer and a foreign descriptor with the stop option set.

// File: rtl/rx_desc_dma_pkg.sv
package rx_desc_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OWN,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_RECV,
        ST_FLUSH,
        ST_DRAIN,
        ST_STATUS
    } rx_state_e;

    // control bits 9:0, most significant field first
    typedef struct packed {
        logic [1:0] pad;
        logic       little;
        logic       addr_down;
        logic       stop_foreign;
        logic [4:0] burst_m1;
    } rx_cfg_t;

    localparam int CTRL_EN_BIT  = 10;
    localparam int CTRL_RST_BIT = 11;

    function automatic logic [4:0] lane_shift(input logic [1:0] lane, input logic little);
        return little ? {lane, 3'b000} : {~lane, 3'b000};
    endfunction

    function automatic logic [31:0] status_word(input logic over, input logic [15:0] n);
        return {1'b0, 14'd0, over, n};
    endfunction

endpackage

// File: rtl/rx_desc_dma_pack.sv
module rx_desc_dma_pack
    import rx_desc_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        init,
    input  logic [1:0]  start_lane,
    input  logic        little,
    input  logic        put,
    input  logic [7:0]  din,
    input  logic        flush,
    output logic        wv,
    output logic [31:0] wd
);
    logic [31:0] acc, nacc;
    logic [1:0]  lane;
    logic        dirty;
    logic        emit;

    always_comb begin
        nacc = acc;
        if (put) nacc[lane_shift(lane, little) +: 8] = din;
        emit = (put && lane == 2'd3) || (flush && (dirty || put));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc   <= '0;
            lane  <= '0;
            dirty <= 1'b0;
            wv    <= 1'b0;
            wd    <= '0;
        end else begin
            wv <= 1'b0;
            if (init) begin
                lane  <= start_lane;
                acc   <= '0;
                dirty <= 1'b0;
            end else if (emit) begin
                wv    <= 1'b1;
                wd    <= nacc;
                acc   <= '0;
                lane  <= '0;
                dirty <= 1'b0;
            end else if (put) begin
                acc   <= nacc;
                lane  <= lane + 2'd1;
                dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_desc_dma_wbuf.sv
module rx_desc_dma_wbuf #(
    parameter int DEPTH = 32,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DW-1:0]                pdata,
    input  logic                         pop,
    output logic [$clog2(DEPTH+1)-1:0]   cnt,
    output logic [DW-1:0]                head,
    output logic                         at_last
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] words [DEPTH];
    logic [CW-1:0] rptr;

    assign head    = words[rptr[IW-1:0]];
    assign at_last = (rptr + CW'(1)) == cnt;

    always_ff @(posedge clk) begin
        if (push) words[cnt[IW-1:0]] <= pdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            rptr <= '0;
        end else begin
            if (push) cnt  <= cnt + CW'(1);
            if (pop)  rptr <= rptr + CW'(1);
        end
    end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rx_desc_dma_pkg::*;
#(
    parameter int AW        = 26,
    parameter int BURST_MAX = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          rx_en,
    output logic [AW-1:0] desc_ptr,
    output logic [15:0]   len_type,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          evt_done,
    output logic          evt_null,
    output logic          evt_not_owner,
    output logic          evt_max_over,
    output logic          evt_early
);
    localparam int CW = $clog2(BURST_MAX+1);

    rx_state_e     st;
    rx_cfg_t       cfg;
    logic [AW-1:0] nextp, waddr;
    logic [15:0]   limit, bcnt;
    logic [7:0]    lt_hi;
    logic          own, mso, eof;

    logic          soft_rst, hs, put, wv, burst_full, buf_last, pop, init;
    logic [31:0]   wd, head;
    logic [CW-1:0] cnt;
    logic          unused_bits;

    assign unused_bits = ^{reg_wdata[31:26], mem_rdata[30:26]};

    assign soft_rst   = reg_we && reg_addr == 2'd0 && reg_wdata[CTRL_RST_BIT];
    assign burst_full = cnt == CW'(cfg.burst_m1);
    assign in_ready   = st == ST_RECV && !(wv && burst_full);
    assign hs         = in_valid && in_ready;
    assign put        = hs && bcnt < limit;
    assign pop        = st == ST_DRAIN && mem_ack;
    assign init       = st == ST_RD_NEXT && mem_ack && own;

    rx_desc_dma_pack u_pack (
        .clk(clk), .rst(rst), .clr(soft_rst), .init(init),
        .start_lane(cfg.pad), .little(cfg.little),
        .put(put), .din(in_data), .flush(hs && in_last),
        .wv(wv), .wd(wd)
    );

    rx_desc_dma_wbuf #(.DEPTH(BURST_MAX), .DW(32)) u_wbuf (
        .clk(clk), .rst(rst), .clr(soft_rst || (pop && buf_last)),
        .push(wv), .pdata(wd), .pop(pop),
        .cnt(cnt), .head(head), .at_last(buf_last)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_ptr;
        mem_wdata = '0;
        unique case (st)
            ST_RD_OWN:  mem_req = 1'b1;
            ST_RD_BUF:  begin mem_req = 1'b1; mem_addr = desc_ptr + AW'(1); end
            ST_RD_NEXT: begin mem_req = 1'b1; mem_addr = desc_ptr + AW'(2); end
            ST_DRAIN:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = waddr; mem_wdata = head; end
            ST_STATUS:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = status_word(mso, bcnt); end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; cfg <= '0; rx_en <= 1'b0; desc_ptr <= '1;
            limit <= '0; bcnt <= '0; nextp <= '0; waddr <= '0;
            own <= 1'b0; mso <= 1'b0; eof <= 1'b0; lt_hi <= '0; len_type <= '0;
            evt_done <= 1'b0; evt_null <= 1'b0; evt_not_owner <= 1'b0;
            evt_max_over <= 1'b0; evt_early <= 1'b0;
        end else begin
            evt_done <= 1'b0; evt_null <= 1'b0; evt_not_owner <= 1'b0;
            evt_max_over <= 1'b0; evt_early <= 1'b0;
            unique case (st)
                ST_IDLE: if (rx_en) begin
                    if (desc_ptr == '0) begin
                        rx_en <= 1'b0;
                        evt_null <= 1'b1;
                    end else st <= ST_RD_OWN;
                end
                ST_RD_OWN: if (mem_ack) begin own <= mem_rdata[31]; st <= ST_RD_BUF; end
                ST_RD_BUF: if (mem_ack) begin waddr <= mem_rdata[AW-1:0]; st <= ST_RD_NEXT; end
                ST_RD_NEXT: if (mem_ack) begin
                    nextp <= mem_rdata[AW-1:0];
                    if (own) begin
                        bcnt <= '0; mso <= 1'b0; eof <= 1'b0; st <= ST_RECV;
                    end else begin
                        evt_not_owner <= 1'b1;
                        st <= ST_IDLE;
                        if (cfg.stop_foreign) rx_en <= 1'b0;
                        else desc_ptr <= mem_rdata[AW-1:0];
                    end
                end
                ST_RECV: begin
                    if (hs) begin
                        bcnt <= bcnt + 16'd1;
                        if (!(bcnt < limit)) mso <= 1'b1;
                        if (bcnt == 16'd12) lt_hi <= in_data;
                        if (bcnt == 16'd13) begin
                            len_type  <= {lt_hi, in_data};
                            evt_early <= 1'b1;
                        end
                    end
                    if (hs && in_last) st <= ST_FLUSH;
                    else if (wv && burst_full) st <= ST_DRAIN;
                end
                ST_FLUSH: begin
                    eof <= 1'b1;
                    st  <= (cnt != '0 || wv) ? ST_DRAIN : ST_STATUS;
                end
                ST_DRAIN: if (mem_ack) begin
                    waddr <= cfg.addr_down ? waddr - AW'(1) : waddr + AW'(1);
                    if (buf_last) st <= eof ? ST_STATUS : ST_RECV;
                end
                ST_STATUS: if (mem_ack) begin
                    desc_ptr     <= nextp;
                    evt_done     <= 1'b1;
                    evt_max_over <= mso;
                    eof          <= 1'b0;
                    st           <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
            if (reg_we) begin
                unique case (reg_addr)
                    2'd0: begin
                        cfg   <= reg_wdata[9:0];
                        rx_en <= reg_wdata[CTRL_EN_BIT] && !reg_wdata[CTRL_RST_BIT];
                        if (reg_wdata[CTRL_RST_BIT]) st <= ST_IDLE;
                    end
                    2'd1: desc_ptr <= reg_wdata[AW-1:0];
                    2'd2: limit    <= reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk
    import rx_desc_dma_pkg::*;
#(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst,
    input rx_state_e     st,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          rx_en,
    input logic          in_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          evt_null,
    input logic          evt_not_owner,
    input logic          evt_early
);
    AST_READY_EXCLUDES_MEM: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !mem_req); // R6

    AST_OWNER_HANDED_BACK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STATUS && mem_req) |-> (mem_we && !mem_wdata[31])); // R5

    AST_NULL_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (evt_null && !$past(reg_we)) |-> !rx_en); // R3

    AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd0 && reg_wdata[11]) |=> (!rx_en && !mem_req && !in_ready)); // R12

    AST_UNIT_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && mem_req && $past(st == ST_DRAIN && mem_req && mem_ack))
        |-> (mem_addr == $past(mem_addr) + AW'(1) || mem_addr == $past(mem_addr) - AW'(1))); // R9

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_null, evt_not_owner, evt_early})); // R4
endmodule

bind rx_desc_dma rx_desc_dma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .st(st),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_en(rx_en), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .evt_null(evt_null), .evt_not_owner(evt_not_owner), .evt_early(evt_early)
);

// File: tb/rx_desc_dma_test.sv
module rx_desc_dma_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rx_en;
    logic [25:0] desc_ptr;
    logic [15:0] len_type;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we, mem_ack;
    logic [25:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        evt_done, evt_null, evt_not_owner, evt_max_over, evt_early;

    always #2.5 clk = ~clk;

    rx_desc_dma uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rx_en(rx_en), .desc_ptr(desc_ptr), .len_type(len_type),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .evt_done(evt_done), .evt_null(evt_null), .evt_not_owner(evt_not_owner),
        .evt_max_over(evt_max_over), .evt_early(evt_early)
    );

    // memory model
    logic [31:0] mem [0:4095];
    logic        pl_we = 1'b0;
    logic [11:0] pl_a = '0;
    logic [31:0] pl_d = '0;
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) begin
        if (pl_we) mem[pl_a] <= pl_d;
        else if (mem_req && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    typedef struct packed { logic is_st; logic [25:0] a; logic [31:0] d; } wr_t;
    wr_t    exp_q[$];
    int     run_q[$];
    int     run_len = 0;
    int     checks = 0, fails = 0;
    int     n_done = 0, n_null = 0, n_nown = 0, n_mso = 0, n_early = 0;
    string  cur_req = "R2";
    logic [7:0] fb [0:63];
    bit     finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // per-clock comparison against the reference write stream
    always @(negedge clk) begin
        bit dw;
        wr_t e;
        dw = 0;
        if (!rst) begin
            if (mem_req && mem_we) begin
                if (exp_q.size() == 0) begin
                    check(0, cur_req, "unexpected write addr", {6'd0, mem_addr}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    dw = !e.is_st;
                    check(mem_addr == e.a, e.is_st ? "R5" : cur_req, "write addr", {6'd0, mem_addr}, {6'd0, e.a});
                    check(mem_wdata == e.d, e.is_st ? "R5" : cur_req, "write data", mem_wdata, e.d);
                end
            end
            if (dw) run_len++;
            else if (run_len > 0) begin
                if (run_q.size() == 0) check(0, "R6", "extra run", run_len, 0);
                else check(run_len == run_q[0], "R6", "burst run length", run_len, run_q[0]);
                if (run_q.size() != 0) void'(run_q.pop_front());
                run_len = 0;
            end
            if (evt_done) n_done++;
            if (evt_null) n_null++;
            if (evt_not_owner) n_nown++;
            if (evt_max_over) n_mso++;
            if (evt_early) n_early++;
        end
    end

    task automatic clr_counts();
        n_done = 0; n_null = 0; n_nown = 0; n_mso = 0; n_early = 0;
    endtask

    task automatic preload(input int a, input logic [31:0] d);
        @(negedge clk); pl_we = 1'b1; pl_a = a[11:0]; pl_d = d;
        @(negedge clk); pl_we = 1'b0;
    endtask

    task automatic put_desc(input int p, input bit own, input int bufa, input int nxt);
        preload(p, {own, 31'd0});
        preload(p + 1, bufa);
        preload(p + 2, nxt);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        @(negedge clk); in_valid = 1'b1; in_data = b; in_last = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_frame(input int n);
        for (int i = 0; i < n; i++) send_byte(fb[i], i == n - 1);
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    endtask

    // independent model of how one frame lands in memory
    task automatic expect_frame(input int bufa, input int dp, input int n, input int pad,
                                input bit little, input bit down, input int burst, input int lim);
        int stored, nw, rem;
        logic [31:0] w;
        wr_t e;
        stored = (n < lim) ? n : lim;
        nw = (stored == 0) ? 0 : (pad + stored + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int s = 0; s < 4; s++) begin
                int i;
                i = k * 4 + s - pad;
                if (i >= 0 && i < stored) begin
                    if (little) w[8*s +: 8] = fb[i];
                    else        w[8*(3-s) +: 8] = fb[i];
                end
            end
            e.is_st = 0; e.a = down ? 26'(bufa - k) : 26'(bufa + k); e.d = w;
            exp_q.push_back(e);
        end
        rem = nw;
        while (rem > 0) begin
            run_q.push_back(rem < burst ? rem : burst);
            rem -= burst;
        end
        e.is_st = 1; e.a = 26'(dp); e.d = {1'b0, 14'd0, (n > lim), 16'(n)};
        exp_q.push_back(e);
    endtask

    task automatic wait_stop();
        int t;
        t = 0;
        while (rx_en && t < 3000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rx_en == 1'b0, "R1", "rx_en after reset", rx_en, 0);
        check(desc_ptr == '1, "R1", "desc_ptr after reset", desc_ptr, 26'h3ffffff);
        check(in_ready == 1'b0 && mem_req == 1'b0, "R1", "ready/req after reset", {in_ready, mem_req}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Scenario 1: big-endian, incrementing, pad 0, burst 4, skip foreign descriptor, null end
        put_desc(32'h100, 1, 32'h200, 32'h110);
        put_desc(32'h110, 0, 32'h280, 32'h120);
        put_desc(32'h120, 1, 32'h240, 32'h0);
        clr_counts();
        cur_req = "R8";
        wr_reg(2'd0, 32'h800);
        wr_reg(2'd1, 32'h100);
        wr_reg(2'd2, 32'd100);
        for (int i = 0; i < 20; i++) fb[i] = 8'(i + 1);
        fb[12] = 8'h08; fb[13] = 8'h00;
        expect_frame(32'h200, 32'h100, 20, 0, 0, 0, 4, 100); // R2 R6 R8
        wr_reg(2'd0, 32'h403);
        send_frame(20);
        for (int i = 0; i < 7; i++) fb[i] = 8'hA0 + 8'(i);
        expect_frame(32'h240, 32'h120, 7, 0, 0, 0, 4, 100);
        send_frame(7);
        wait_stop();
        check(rx_en == 1'b0, "R3", "enable after null pointer", rx_en, 0);
        check(desc_ptr == 26'd0, "R2", "pointer after chain", desc_ptr, 0);
        check(n_null == 1, "R3", "null events", n_null, 1);
        check(n_nown == 1, "R4", "skip events", n_nown, 1);
        check(n_done == 2, "R5", "done events", n_done, 2);
        check(n_early == 1, "R11", "early events", n_early, 1);
        check(len_type == 16'h0800, "R11", "len_type", len_type, 16'h0800);
        check(exp_q.size() == 0, "R2", "writes outstanding", exp_q.size(), 0);
        check(mem[12'h110][31] == 1'b0, "R4", "foreign descriptor untouched", mem[12'h110], 0);

        // Scenario 2: little-endian, decrementing, pad 3, burst 2, limit 10, stop on foreign
        put_desc(32'h400, 1, 32'h500, 32'h410);
        put_desc(32'h410, 0, 32'h580, 32'h420);
        clr_counts();
        cur_req = "R9";
        wr_reg(2'd0, 32'h800);
        wr_reg(2'd1, 32'h400);
        wr_reg(2'd2, 32'd10);
        for (int i = 0; i < 16; i++) fb[i] = 8'h30 + 8'(i);
        fb[12] = 8'h12; fb[13] = 8'h34;
        expect_frame(32'h500, 32'h400, 16, 3, 1, 1, 2, 10); // R7 R8 R9 R10
        wr_reg(2'd0, 32'h400 | (3 << 8) | (1 << 7) | (1 << 6) | (1 << 5) | 1);
        send_frame(16);
        wait_stop();
        check(rx_en == 1'b0, "R4", "enable after foreign stop", rx_en, 0);
        check(desc_ptr == 26'h410, "R4", "pointer kept on stop", desc_ptr, 26'h410);
        check(n_nown == 1, "R4", "not-owner events", n_nown, 1);
        check(n_mso == 1, "R10", "over-limit events", n_mso, 1);
        check(n_null == 0, "R3", "no null event", n_null, 0);
        check(len_type == 16'h1234, "R11", "len_type beyond limit", len_type, 16'h1234);
        check(exp_q.size() == 0, "R7", "writes outstanding", exp_q.size(), 0);

        // Scenario 3: pad 1, burst 1, frame exactly at the limit
        put_desc(32'h600, 1, 32'h700, 32'h0);
        clr_counts();
        cur_req = "R7";
        wr_reg(2'd0, 32'h800);
        wr_reg(2'd1, 32'h600);
        wr_reg(2'd2, 32'd3);
        fb[0] = 8'hC1; fb[1] = 8'hC2; fb[2] = 8'hC3;
        expect_frame(32'h700, 32'h600, 3, 1, 0, 0, 1, 3);
        wr_reg(2'd0, 32'h400 | (1 << 8));
        send_frame(3);
        wait_stop();
        check(n_mso == 0, "R10", "no over-limit at exact limit", n_mso, 0);
        check(n_done == 1, "R5", "done events", n_done, 1);
        check(n_early == 0, "R11", "no early on short frame", n_early, 0);
        check(exp_q.size() == 0, "R7", "writes outstanding", exp_q.size(), 0);

        // Scenario 4: soft reset in mid-frame, then restart on the same descriptor
        put_desc(32'h800, 1, 32'h900, 32'h0);
        clr_counts();
        cur_req = "R12";
        wr_reg(2'd0, 32'h800);
        wr_reg(2'd1, 32'h800);
        wr_reg(2'd2, 32'd100);
        wr_reg(2'd0, 32'h403);
        for (int i = 0; i < 5; i++) send_byte(8'h50 + 8'(i), 0);
        @(negedge clk); in_valid = 1'b0;
        wr_reg(2'd0, 32'h800 | 32'h403);
        repeat (10) @(negedge clk);
        check(rx_en == 1'b0, "R12", "enable after soft reset", rx_en, 0);
        check(in_ready == 1'b0, "R12", "ready after soft reset", in_ready, 0);
        check(mem[12'h800][31] == 1'b1, "R12", "descriptor still owned", mem[12'h800], 32'h80000000);
        check(n_done == 0, "R12", "no done after soft reset", n_done, 0);
        wr_reg(2'd1, 32'h800);
        for (int i = 0; i < 4; i++) fb[i] = 8'hE0 + 8'(i);
        expect_frame(32'h900, 32'h800, 4, 0, 0, 0, 1, 100);
        wr_reg(2'd0, 32'h400);
        send_frame(4);
        wait_stop();
        check(n_done == 1, "R12", "restart completes frame", n_done, 1);
        check(exp_q.size() == 0 && run_q.size() == 0, "R6", "expected stream drained",
              exp_q.size() + run_q.size(), 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule